// File: doc/BRIEF.md
# Transceiver PLL Retune Reset Sequencer

This block steps a group of serial transceiver channels through a safe retune of the PLL they share. On a retune request it drives the transmit digital reset, receive analog reset and receive digital reset high. While they stay high, it asks an external reconfiguration engine to rewrite the PLL. It then asks the same engine to reconfigure every channel on that PLL, one channel at a time.

The channel pass always follows the PLL update, even when the recovered clocks already look right. The pass refreshes the inputs of the receiver's frequency-lock detector, and without it that lock can stay low for good. When the last channel is done, transmit digital reset and receive analog reset are released together. Receive digital reset is held until receiver frequency lock has stayed high for a minimum hold-off time. The time is set in nanoseconds and converted to clock cycles from the clock-frequency parameter, rounding up.

The engine has two start/busy/done handshakes, one for the PLL and one for the channels. A channel index output names the channel that each channel start refers to.

Top module: `xcvr_retune_seq`

## Requirements
- R1: In the cycle after a retune request is accepted in idle, `tx_dig_rst`, `rx_ana_rst` and `rx_dig_rst` are all 1. They stay 1 through the PLL update and every channel start.
- R2: `pll_start` is a one-cycle pulse raised only while `pll_busy` is 0. No `chan_start` occurs in a sequence before `pll_done` has pulsed in that sequence.
- R3: Each sequence issues exactly NUM_CHANNELS channel starts. `chan_idx` is 0, 1, … NUM_CHANNELS-1 in that order, and it moves to the next channel only after `chan_done` for the current one.
- R4: In the cycle after `chan_done` for the last channel, `tx_dig_rst` and `rx_ana_rst` fall together while `rx_dig_rst` stays 1.
- R5: With `rx_freq_lock` held high, `rx_dig_rst` falls no sooner than HOLD_NS after lock rises, and no more than two clock cycles after that.
- R6: If `rx_freq_lock` drops during the hold-off, the wait starts over. The full HOLD_NS is measured again from the next rise of lock.
- R7: `seq_busy` is 1 from the cycle after the request until the cycle `rx_dig_rst` falls. A `retune_req` while `seq_busy` is 1 is ignored: it starts no second PLL update.
- R8: `seq_done` is a one-cycle pulse in the same cycle that `rx_dig_rst` falls. At that point `seq_busy` is 0 and all three resets are 0.
- R9: While `rst_n` is 0 at a clock edge, all three transceiver resets become 1, `seq_busy` becomes 0, and no start pulse is driven.
- R10: `chan_start` is raised only while `chan_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| retune_req | input | 1 | Request a PLL retune sequence |
| pll_start | output | 1 | Start PLL reconfiguration (one-cycle pulse) |
| pll_busy | input | 1 | Engine is busy with a PLL update |
| pll_done | input | 1 | PLL update finished (pulse) |
| chan_start | output | 1 | Start channel reconfiguration (one-cycle pulse) |
| chan_idx | output | CH_W | Channel being reconfigured |
| chan_busy | input | 1 | Engine is busy with a channel update |
| chan_done | input | 1 | Channel update finished (pulse) |
| rx_freq_lock | input | 1 | Receiver frequency lock |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receive analog reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Sequence complete (one-cycle pulse) |

## Verification
The bench runs the sequence with short and long engine latencies. One run keeps the channel engine busy when the PLL update finishes, which shows whether a channel start waits for `chan_busy`. Another run sends a second request in the middle of a sequence, which shows whether requests are ignored while busy. A run where lock drops partway through the hold-off shows a counter that restarts apart from one that only pauses. Sequencer resets are applied both after a finished sequence and in the middle of the channel pass, and a further full run after that shows the block recovers.

// File: rtl/xrs_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the retune reset sequencer.
package xrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLL_REQ,
        ST_PLL_WAIT,
        ST_CH_REQ,
        ST_CH_WAIT,
        ST_LOCK_WAIT
    } seq_state_t;
endpackage

// File: rtl/xrs_holdoff_timer.sv
`timescale 1ns/1ps
// Hold-off timer: counts consecutive cycles of frequency lock while armed.
// It flags expiry once HOLD_CYCLES full cycles of lock have been counted.
// Assumes: lock is already synchronous to clk. Losing lock or disarming clears the count.
module xrs_holdoff_timer #(
    parameter int HOLD_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic lock,
    output logic expired
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] TERM = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt;

    // Count cycles of lock while armed; saturate at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !lock) begin
            cnt <= '0;
        end else if (cnt != TERM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry: armed, still locked, and the full window has been counted.
    always_comb expired = arm && lock && (cnt == TERM);
endmodule

// File: rtl/xrs_chan_counter.sv
`timescale 1ns/1ps
// Channel index counter: walks 0..NUM_CHANNELS-1 during the channel pass.
// Assumes: clear and adv are never high together.
module xrs_chan_counter #(
    parameter int NUM_CHANNELS = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            adv,
    output logic [CH_W-1:0] idx,
    output logic            last
);
    localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CHANNELS - 1);

    // Hold, clear or step the current channel index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else if (adv && !last) begin
            idx <= idx + 1'b1;
        end
    end

    // Flag the final channel of the pass.
    always_comb last = (idx == LAST_IDX);
endmodule

// File: rtl/xrs_ctrl_fsm.sv
`timescale 1ns/1ps
// Control FSM: orders reset assertion, PLL update, channel pass, staged
// release and hold-off.
// Assumes: done inputs are single-cycle pulses, and each one answers the
// start issued for it.
module xrs_ctrl_fsm
    import xrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic retune_req,
    input  logic pll_busy,
    input  logic pll_done,
    input  logic chan_busy,
    input  logic chan_done,
    input  logic chan_last,
    input  logic hold_expired,
    output logic pll_start,
    output logic chan_start,
    output logic idx_clear,
    output logic idx_adv,
    output logic hold_arm,
    output logic tx_dig_rst,
    output logic rx_ana_rst,
    output logic rx_dig_rst,
    output logic seq_busy,
    output logic seq_done
);
    seq_state_t state, state_nxt;

    // Next-state selection.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (retune_req)                state_nxt = ST_PLL_REQ;
            ST_PLL_REQ:   if (!pll_busy)                 state_nxt = ST_PLL_WAIT;
            ST_PLL_WAIT:  if (pll_done)                  state_nxt = ST_CH_REQ;
            ST_CH_REQ:    if (!chan_busy)                state_nxt = ST_CH_WAIT;
            ST_CH_WAIT:   if (chan_done)                 state_nxt = chan_last ? ST_LOCK_WAIT : ST_CH_REQ;
            ST_LOCK_WAIT: if (hold_expired)              state_nxt = ST_IDLE;
            default:                                     state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Registered reset lines and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_dig_rst <= 1'b1;
            rx_ana_rst <= 1'b1;
            rx_dig_rst <= 1'b1;
            seq_done   <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            if (state == ST_IDLE && retune_req) begin
                tx_dig_rst <= 1'b1;
                rx_ana_rst <= 1'b1;
                rx_dig_rst <= 1'b1;
            end
            if (state == ST_CH_WAIT && chan_done && chan_last) begin
                tx_dig_rst <= 1'b0;
                rx_ana_rst <= 1'b0;
            end
            if (state == ST_LOCK_WAIT && hold_expired) begin
                rx_dig_rst <= 1'b0;
                seq_done   <= 1'b1;
            end
        end
    end

    // Handshake strobes and datapath controls decoded from state.
    always_comb begin
        pll_start  = (state == ST_PLL_REQ) && !pll_busy;
        chan_start = (state == ST_CH_REQ) && !chan_busy;
        idx_clear  = (state == ST_PLL_WAIT) && pll_done;
        idx_adv    = (state == ST_CH_WAIT) && chan_done;
        hold_arm   = (state == ST_LOCK_WAIT);
        seq_busy   = (state != ST_IDLE);
    end
endmodule

// File: rtl/xcvr_retune_seq.sv
`timescale 1ns/1ps
// Top: transceiver PLL retune reset sequencer.
// It holds the transceiver resets through a PLL update and a per-channel
// reconfiguration pass. Then it releases them in stages, with a lock-based
// hold-off before receive digital reset is released.
// Assumes: one engine serves both handshakes, and its inputs are synchronous to clk.
module xcvr_retune_seq #(
    parameter int NUM_CHANNELS = 4,
    parameter int CLK_MHZ      = 100,
    parameter int HOLD_NS      = 4000,
    parameter int CH_W         = (NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retune_req,
    output logic            pll_start,
    input  logic            pll_busy,
    input  logic            pll_done,
    output logic            chan_start,
    output logic [CH_W-1:0] chan_idx,
    input  logic            chan_busy,
    input  logic            chan_done,
    input  logic            rx_freq_lock,
    output logic            tx_dig_rst,
    output logic            rx_ana_rst,
    output logic            rx_dig_rst,
    output logic            seq_busy,
    output logic            seq_done
);
    // Round up so the hold-off is never shorter than HOLD_NS.
    localparam int HOLD_CYCLES = (CLK_MHZ * HOLD_NS + 999) / 1000;

    logic idx_clear, idx_adv, chan_last, hold_arm, hold_expired;

    xrs_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .retune_req   (retune_req),
        .pll_busy     (pll_busy),
        .pll_done     (pll_done),
        .chan_busy    (chan_busy),
        .chan_done    (chan_done),
        .chan_last    (chan_last),
        .hold_expired (hold_expired),
        .pll_start    (pll_start),
        .chan_start   (chan_start),
        .idx_clear    (idx_clear),
        .idx_adv      (idx_adv),
        .hold_arm     (hold_arm),
        .tx_dig_rst   (tx_dig_rst),
        .rx_ana_rst   (rx_ana_rst),
        .rx_dig_rst   (rx_dig_rst),
        .seq_busy     (seq_busy),
        .seq_done     (seq_done)
    );

    xrs_chan_counter #(
        .NUM_CHANNELS (NUM_CHANNELS),
        .CH_W         (CH_W)
    ) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idx_clear),
        .adv   (idx_adv),
        .idx   (chan_idx),
        .last  (chan_last)
    );

    xrs_holdoff_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (hold_arm),
        .lock    (rx_freq_lock),
        .expired (hold_expired)
    );
endmodule

// File: rtl/xcvr_retune_seq_chk.sv
`timescale 1ns/1ps
// Checker: port-level protocol properties of the retune sequencer.
module xcvr_retune_seq_chk #(
    parameter int NUM_CHANNELS = 4,
    parameter int CH_W         = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            retune_req,
    input logic            pll_start,
    input logic            pll_busy,
    input logic            chan_start,
    input logic [CH_W-1:0] chan_idx,
    input logic            chan_busy,
    input logic            rx_freq_lock,
    input logic            tx_dig_rst,
    input logic            rx_ana_rst,
    input logic            rx_dig_rst,
    input logic            seq_busy,
    input logic            seq_done
);
    AST_REQ_ASSERTS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && retune_req) |=> (tx_dig_rst && rx_ana_rst && rx_dig_rst && seq_busy)); // R1
    AST_RESETS_HELD_ON_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start |-> (tx_dig_rst && rx_ana_rst && rx_dig_rst)); // R1
    AST_PLL_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_start |-> !pll_busy); // R2
    AST_PLL_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_start |=> !pll_start); // R2
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start |-> (int'(chan_idx) < NUM_CHANNELS)); // R3
    AST_RX_DIG_WAITS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dig_rst) |-> $past(rx_freq_lock)); // R5
    AST_RX_DIG_FALLS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dig_rst) |-> (seq_done && !seq_busy)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R8
    AST_CHAN_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start |-> !chan_busy); // R10
endmodule

bind xcvr_retune_seq xcvr_retune_seq_chk #(
    .NUM_CHANNELS (NUM_CHANNELS),
    .CH_W         (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .retune_req   (retune_req),
    .pll_start    (pll_start),
    .pll_busy     (pll_busy),
    .chan_start   (chan_start),
    .chan_idx     (chan_idx),
    .chan_busy    (chan_busy),
    .rx_freq_lock (rx_freq_lock),
    .tx_dig_rst   (tx_dig_rst),
    .rx_ana_rst   (rx_ana_rst),
    .rx_dig_rst   (rx_dig_rst),
    .seq_busy     (seq_busy),
    .seq_done     (seq_done)
);

// File: tb/xcvr_retune_seq_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected channel indices, and a
// negedge monitor pops one for each channel start and compares.
module xcvr_retune_seq_tb;
    localparam int NCH  = 4;
    localparam int CH_W = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, retune_req = 1'b0;
    logic pll_busy = 1'b0, pll_done = 1'b0;
    logic ch_busy_a = 1'b0, ch_busy_b = 1'b0, chan_done = 1'b0;
    logic rx_freq_lock = 1'b0;
    logic chan_busy;
    logic pll_start, chan_start, tx_dig_rst, rx_ana_rst, rx_dig_rst, seq_busy, seq_done;
    logic [CH_W-1:0] chan_idx;

    assign chan_busy = ch_busy_a | ch_busy_b;

    xcvr_retune_seq #(.NUM_CHANNELS(NCH), .CLK_MHZ(100), .HOLD_NS(4000)) u_dut (
        .clk(clk), .rst_n(rst_n), .retune_req(retune_req),
        .pll_start(pll_start), .pll_busy(pll_busy), .pll_done(pll_done),
        .chan_start(chan_start), .chan_idx(chan_idx), .chan_busy(chan_busy),
        .chan_done(chan_done), .rx_freq_lock(rx_freq_lock),
        .tx_dig_rst(tx_dig_rst), .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst),
        .seq_busy(seq_busy), .seq_done(seq_done)
    );

    int checks = 0, errors = 0, cyc = 0;
    int pll_lat = 3, ch_lat = 2;
    bit pre_busy = 1'b0, pll_done_seen = 1'b0, finished = 1'b0;
    int pll_starts = 0, chan_starts = 0, last_done_cyc = -10;
    int exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // PLL engine responder, with an optional channel-busy window after done.
    initial forever begin
        @(posedge clk);
        if (pll_start) begin
            #1 pll_busy = 1'b1;
            repeat (pll_lat) @(posedge clk);
            #1 pll_busy = 1'b0; pll_done = 1'b1;
            if (pre_busy) ch_busy_b = 1'b1;
            @(posedge clk);
            #1 pll_done = 1'b0;
            if (pre_busy) begin
                repeat (4) @(posedge clk);
                #1 ch_busy_b = 1'b0;
            end
        end
    end

    // Channel engine responder.
    initial forever begin
        @(posedge clk);
        if (chan_start) begin
            #1 ch_busy_a = 1'b1;
            repeat (ch_lat) @(posedge clk);
            #1 ch_busy_a = 1'b0; chan_done = 1'b1;
            @(posedge clk);
            #1 chan_done = 1'b0;
        end
    end

    // Monitor: scoreboard pop on channel start, plus handshake rules.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pll_done) pll_done_seen = 1'b1;
            if (chan_done) last_done_cyc = cyc;
            if (pll_start) begin
                pll_starts++;
                check(!pll_busy, "R2", "pll_start while busy", int'(pll_busy), 0);
            end
            if (chan_start) begin
                chan_starts++;
                check(!chan_busy, "R10", "chan_start while busy", int'(chan_busy), 0);
                check(pll_done_seen, "R2", "chan_start before pll_done", int'(pll_done_seen), 1);
                check(tx_dig_rst && rx_ana_rst && rx_dig_rst, "R1", "resets during chan pass",
                      int'({tx_dig_rst, rx_ana_rst, rx_dig_rst}), 7);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected chan_start idx", int'(chan_idx), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(chan_idx) == e, "R3", "chan_idx order", int'(chan_idx), e);
                end
            end
        end
    end

    // Driver: one full retune with the given engine behaviour.
    task automatic run_retune(input int pl, input int cl, input bit pb,
                              input bit extra_req, input bit drop_lock);
        realtime t0, t1;
        int dt;
        exp_q.delete();
        for (int i = 0; i < NCH; i++) exp_q.push_back(i);
        pll_lat = pl; ch_lat = cl; pre_busy = pb;
        @(posedge clk);
        #1 rx_freq_lock = 1'b0; pll_done_seen = 1'b0; pll_starts = 0; chan_starts = 0;
        retune_req = 1'b1;
        @(posedge clk);
        #1 retune_req = 1'b0;
        @(negedge clk);
        check(tx_dig_rst && rx_ana_rst && rx_dig_rst, "R1", "resets after request",
              int'({tx_dig_rst, rx_ana_rst, rx_dig_rst}), 7);
        check(seq_busy, "R7", "busy after request", int'(seq_busy), 1);
        if (extra_req) begin
            while (!pll_busy) @(negedge clk);
            @(posedge clk); #1 retune_req = 1'b1;
            @(posedge clk); #1 retune_req = 1'b0;
        end
        while (tx_dig_rst) @(negedge clk);
        check(cyc == last_done_cyc + 1, "R4", "tx/rx-analog release cycle", cyc, last_done_cyc + 1);
        check(!rx_ana_rst, "R4", "rx_ana_rst released with tx", int'(rx_ana_rst), 0);
        check(rx_dig_rst, "R4", "rx_dig_rst still held", int'(rx_dig_rst), 1);
        check(exp_q.size() == 0 && chan_starts == NCH, "R3", "channel starts per pass", chan_starts, NCH);
        check(pll_starts == 1, "R7", "PLL starts per sequence", pll_starts, 1);
        repeat (3) @(posedge clk);
        #1 rx_freq_lock = 1'b1; t0 = $realtime;
        if (drop_lock) begin
            repeat (200) @(posedge clk);
            #1 rx_freq_lock = 1'b0;
            repeat (3) @(posedge clk);
            #1 rx_freq_lock = 1'b1; t0 = $realtime;
        end
        while (!seq_done) @(negedge clk);
        t1 = $realtime;
        dt = int'(t1 - t0);
        check(dt >= 4000 && dt <= 4030, drop_lock ? "R6" : "R5", "hold-off ns", dt, 4000);
        check(!rx_dig_rst && !seq_busy, "R8", "release with done",
              int'({rx_dig_rst, seq_busy}), 0);
        @(negedge clk);
        check(!seq_done, "R8", "done is one cycle", int'(seq_done), 0);
        check(!tx_dig_rst && !rx_ana_rst && !rx_dig_rst && !seq_busy, "R8", "idle after done",
              int'({tx_dig_rst, rx_ana_rst, rx_dig_rst, seq_busy}), 0);
        check(pll_starts == 1, "R7", "no extra sequence", pll_starts, 1);
    endtask

    task automatic check_reset_state(input string what);
        check(tx_dig_rst && rx_ana_rst && rx_dig_rst, "R9", what,
              int'({tx_dig_rst, rx_ana_rst, rx_dig_rst}), 7);
        check(!seq_busy && !pll_start && !chan_start, "R9", "idle under reset",
              int'({seq_busy, pll_start, chan_start}), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_reset_state("initial reset state");
        @(posedge clk); #1 rst_n = 1'b1;
        run_retune(3, 2, 1'b0, 1'b0, 1'b0);
        run_retune(7, 5, 1'b1, 1'b1, 1'b0);
        run_retune(1, 1, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_reset_state("reset after finished sequence");
        #1 rst_n = 1'b1;
        exp_q.delete(); exp_q.push_back(0); exp_q.push_back(1);
        pll_done_seen = 1'b0;
        @(posedge clk); #1 retune_req = 1'b1;
        @(posedge clk); #1 retune_req = 1'b0;
        while (chan_starts == 0 || chan_idx == 0) @(negedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_reset_state("reset mid channel pass");
        #1 rst_n = 1'b1;
        repeat (12) @(posedge clk);
        run_retune(2, 3, 1'b0, 1'b0, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1500000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule